// File: doc/BRIEF.md
# Bus-Mapped GPIO Port Controller

This block is an eight-pin general purpose I/O port. It holds a data register and a direction register, both reached over a simple synchronous register bus with a select, a write flag, an address and write data. Each bit of the direction register enables the output driver of its pin, and the pin is then driven from the data register. A read of the data register chooses, bit by bit, between the stored value and the pin input after it has passed through a two-flop synchronizer. The lowest pins are input only, and their direction bits are fixed at zero.

After reset is released, the data register takes a snapshot of the synchronized pin states on a fixed clock edge. This lets software read the levels the pins held while reset was active. An emulation-mode input sends data-register reads to an external bus data input, and copies data-register writes onto an external write strobe. While reset is held low, the block asserts pull-up and pull-down enable outputs for a fixed set of pins. The pad drivers and the pull devices themselves sit outside the block.

Top module: `gpio_port_ctrl`

## Requirements
- R1: Offset 0x08 selects the data register and offset 0x09 selects the direction register. A write takes effect on the rising clock edge while `bus_sel`=1 and `bus_wr`=1. While `bus_sel`=1 and `bus_wr`=0, `bus_rdata` shows the addressed register in the same cycle.
- R2: While `rst_n` is low, the data and direction registers are zero, `pin_oe` is 0x00 and `pin_out` is 0x00.
- R3: On the second rising clock edge after `rst_n` goes high, the data register loads the synchronized pin inputs. If a bus write to the data register falls on that same edge, the written value is stored instead.
- R4: A data-register read returns the stored bit where the direction bit is 1. Where the direction bit is 0, it returns the synchronized pin, which is `pin_in` as sampled two rising edges earlier.
- R5: Direction bits 1 and 0 always read 0 and ignore writes, so `pin_oe[1:0]` is always 0.
- R6: `pin_oe` equals the direction register. `pin_out` carries the data bit where the direction bit is 1 and 0 elsewhere. A data write stores its value whatever the direction bits are, and a later direction change to 1 drives that stored value at once.
- R7: While `emu_mode`=1, a data-register read returns `ext_rdata`. A data-register write raises `ext_wr` in the same cycle with `ext_wdata`=`bus_wdata`, and it still updates the data register. `ext_wr` is 0 at all other times.
- R8: While `rst_n` is low, `pull_up_en`=0x88 (pins 7 and 3) and `pull_dn_en`=0x60 (pins 6 and 5). Both are 0x00 while `rst_n` is high.
- R9: A read of any offset other than 0x08 or 0x09 returns 0x00, and a write to such an offset changes nothing. `bus_rdata` is 0x00 whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| emu_mode | input | 1 | Sends data-register accesses to the external bus |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the read |
| ext_rdata | input | 8 | External bus read data used in emulation mode |
| ext_wr | output | 1 | External bus write strobe |
| ext_wdata | output | 8 | External bus write data |
| pin_in | input | 8 | Raw pin levels |
| pin_out | output | 8 | Output level for each pin |
| pin_oe | output | 8 | Output enable for each pin |
| pull_up_en | output | 8 | Pull-up enables, active during reset |
| pull_dn_en | output | 8 | Pull-down enables, active during reset |

## Verification
The post-reset snapshot of the pins and a bus write to the data register can both land on the same clock edge. The bench provokes this by issuing a data write in the first cycle after reset is released, so that the write commits on the snapshot edge. It then sets the direction bits and expects `pin_out` to show the written value rather than the pin levels. The same race also occurs at random during the randomized phase, which includes a mid-run reset. On every clock the reference model resolves it the same way and compares all outputs.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;

   // decoded register target of a bus cycle
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_DATA = 2'd1,
      ACC_DIR  = 2'd2
   } gpio_acc_e;

endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   // shift chain, no reset so that pin levels flow through during reset
   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk) begin
      stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
`timescale 1ns/1ps
module gpio_port_regs #(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned IN_ONLY     = 2,
   parameter int unsigned CAPTURE_DLY = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_data,
   input  logic             wr_dir,
   input  logic [WIDTH-1:0] wdata,
   input  logic [WIDTH-1:0] pins_sync,
   output logic [WIDTH-1:0] data_q,
   output logic [WIDTH-1:0] dir_q
);

   localparam int unsigned CW = $clog2(CAPTURE_DLY + 1);

   if (CAPTURE_DLY < 1) begin : g_bad_dly
      $error("gpio_port_regs: CAPTURE_DLY must be at least 1");
   end

   logic [CW-1:0] cap_cnt;
   logic          cap_now;

   assign cap_now = (cap_cnt == CW'(CAPTURE_DLY - 1));

   // counts edges since reset release, saturates after the snapshot
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_cnt <= '0;
      end else if (cap_cnt != CW'(CAPTURE_DLY)) begin
         cap_cnt <= cap_cnt + 1'b1;
      end
   end

   // bus write has priority over the snapshot on the same edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (wr_data) begin
         data_q <= wdata;
      end else if (cap_now) begin
         data_q <= pins_sync;
      end
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_dir
      if (b < IN_ONLY) begin : g_fixed
         assign dir_q[b] = 1'b0;
      end else begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dir_q[b] <= 1'b0;
            end else if (wr_dir) begin
               dir_q[b] <= wdata[b];
            end
         end
      end
   end

endmodule

// File: rtl/gpio_port_rdmux.sv
`timescale 1ns/1ps
module gpio_port_rdmux
   import gpio_port_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic             rd_en,
   input  gpio_acc_e        acc,
   input  logic             emu_mode,
   input  logic [WIDTH-1:0] data_q,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] pins_sync,
   input  logic [WIDTH-1:0] ext_rdata,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] port_view;

   // per-bit choice: stored value for outputs, pin level for inputs
   assign port_view = (dir_q & data_q) | (~dir_q & pins_sync);

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         case (acc)
            ACC_DATA: rdata = emu_mode ? ext_rdata : port_view;
            ACC_DIR:  rdata = dir_q;
            default:  rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/gpio_port_ctrl.sv
`timescale 1ns/1ps
module gpio_port_ctrl
   import gpio_port_pkg::*;
#(
   parameter int unsigned       WIDTH       = 8,
   parameter int unsigned       IN_ONLY     = 2,
   parameter int unsigned       ADDR_W      = 8,
   parameter logic [ADDR_W-1:0] DATA_OFS    = 8'h08,
   parameter logic [ADDR_W-1:0] DIR_OFS     = 8'h09,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter int unsigned       CAPTURE_DLY = 2,
   parameter logic [WIDTH-1:0]  PULLUP_MSK  = 8'h88,
   parameter logic [WIDTH-1:0]  PULLDN_MSK  = 8'h60
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              emu_mode,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic [WIDTH-1:0]  ext_rdata,
   output logic              ext_wr,
   output logic [WIDTH-1:0]  ext_wdata,
   input  logic [WIDTH-1:0]  pin_in,
   output logic [WIDTH-1:0]  pin_out,
   output logic [WIDTH-1:0]  pin_oe,
   output logic [WIDTH-1:0]  pull_up_en,
   output logic [WIDTH-1:0]  pull_dn_en
);

   if (IN_ONLY >= WIDTH) begin : g_bad_inonly
      $error("gpio_port_ctrl: IN_ONLY must be below WIDTH");
   end
   if (DATA_OFS == DIR_OFS) begin : g_bad_ofs
      $error("gpio_port_ctrl: register offsets must differ");
   end

   gpio_acc_e        acc;
   logic [WIDTH-1:0] pins_sync;
   logic [WIDTH-1:0] data_q;
   logic [WIDTH-1:0] dir_q;
   logic             rd_en;
   logic             wr_data;
   logic             wr_dir;

   always_comb begin
      acc = ACC_NONE;
      if (bus_sel) begin
         if (bus_addr == DATA_OFS) begin
            acc = ACC_DATA;
         end else if (bus_addr == DIR_OFS) begin
            acc = ACC_DIR;
         end
      end
   end

   assign rd_en   = bus_sel & ~bus_wr;
   assign wr_data = bus_wr & (acc == ACC_DATA);
   assign wr_dir  = bus_wr & (acc == ACC_DIR);

   gpio_sync #(
      .WIDTH  (WIDTH),
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk (clk),
      .d   (pin_in),
      .q   (pins_sync)
   );

   gpio_port_regs #(
      .WIDTH       (WIDTH),
      .IN_ONLY     (IN_ONLY),
      .CAPTURE_DLY (CAPTURE_DLY)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_data   (wr_data),
      .wr_dir    (wr_dir),
      .wdata     (bus_wdata),
      .pins_sync (pins_sync),
      .data_q    (data_q),
      .dir_q     (dir_q)
   );

   gpio_port_rdmux #(
      .WIDTH (WIDTH)
   ) i_rdmux (
      .rd_en     (rd_en),
      .acc       (acc),
      .emu_mode  (emu_mode),
      .data_q    (data_q),
      .dir_q     (dir_q),
      .pins_sync (pins_sync),
      .ext_rdata (ext_rdata),
      .rdata     (bus_rdata)
   );

   assign pin_oe    = dir_q;
   assign pin_out   = data_q & dir_q;
   assign ext_wr    = emu_mode & wr_data;
   assign ext_wdata = bus_wdata;

   // pull enables follow the reset pin directly
   for (genvar b = 0; b < WIDTH; b++) begin : g_pull
      if (PULLUP_MSK[b]) begin : g_up
         assign pull_up_en[b] = ~rst_n;
      end else begin : g_no_up
         assign pull_up_en[b] = 1'b0;
      end
      if (PULLDN_MSK[b]) begin : g_dn
         assign pull_dn_en[b] = ~rst_n;
      end else begin : g_no_dn
         assign pull_dn_en[b] = 1'b0;
      end
   end

endmodule

// File: rtl/gpio_port_chk.sv
`timescale 1ns/1ps
module gpio_port_chk #(
   parameter int unsigned       WIDTH    = 8,
   parameter int unsigned       IN_ONLY  = 2,
   parameter int unsigned       ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] DATA_OFS = 8'h08,
   parameter logic [ADDR_W-1:0] DIR_OFS  = 8'h09
) (
   input logic              clk,
   input logic              rst_n,
   input logic              emu_mode,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [WIDTH-1:0]  bus_wdata,
   input logic [WIDTH-1:0]  bus_rdata,
   input logic [WIDTH-1:0]  ext_rdata,
   input logic              ext_wr,
   input logic [WIDTH-1:0]  pin_out,
   input logic [WIDTH-1:0]  pin_oe,
   input logic [WIDTH-1:0]  pull_up_en,
   input logic [WIDTH-1:0]  pull_dn_en
);

   localparam logic [WIDTH-1:0] DIR_MSK = {{(WIDTH-IN_ONLY){1'b1}}, {IN_ONLY{1'b0}}};

   logic dir_write;
   logic is_mapped;
   assign dir_write = bus_sel && bus_wr && (bus_addr == DIR_OFS);
   assign is_mapped = (bus_addr == DATA_OFS) || (bus_addr == DIR_OFS);

   p_dir_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      dir_write |=> pin_oe == ($past(bus_wdata) & DIR_MSK));

   p_oe_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_write |=> $stable(pin_oe));

   p_out_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out & ~pin_oe) == '0);

   p_oe_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe[IN_ONLY-1:0] == '0);

   p_dir_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr == DIR_OFS) |-> bus_rdata[IN_ONLY-1:0] == '0);

   p_ext_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ext_wr == (emu_mode && bus_sel && bus_wr && bus_addr == DATA_OFS));

   p_emu_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (emu_mode && bus_sel && !bus_wr && bus_addr == DATA_OFS) |-> bus_rdata == ext_rdata);

   p_pull_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pull_up_en == '0 && pull_dn_en == '0);

   p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_sel || bus_wr || !is_mapped) |-> bus_rdata == '0);

endmodule

bind gpio_port_ctrl gpio_port_chk #(
   .WIDTH    (WIDTH),
   .IN_ONLY  (IN_ONLY),
   .ADDR_W   (ADDR_W),
   .DATA_OFS (DATA_OFS),
   .DIR_OFS  (DIR_OFS)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .emu_mode   (emu_mode),
   .bus_sel    (bus_sel),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .bus_rdata  (bus_rdata),
   .ext_rdata  (ext_rdata),
   .ext_wr     (ext_wr),
   .pin_out    (pin_out),
   .pin_oe     (pin_oe),
   .pull_up_en (pull_up_en),
   .pull_dn_en (pull_dn_en)
);

// File: tb/test_gpio_port_ctrl.sv
`timescale 1ns/1ps
module test_gpio_port_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       emu_mode = 1'b0;
   logic       bus_sel = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] ext_rdata = 8'h00;
   logic [7:0] pin_in = 8'hA5;
   logic [7:0] bus_rdata, ext_wdata, pin_out, pin_oe, pull_up_en, pull_dn_en;
   logic       ext_wr;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   gpio_port_ctrl i_gpio_port_ctrl (
      .clk(clk), .rst_n(rst_n), .emu_mode(emu_mode), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ext_rdata(ext_rdata), .ext_wr(ext_wr), .ext_wdata(ext_wdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .pull_up_en(pull_up_en), .pull_dn_en(pull_dn_en)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [7:0] m_data = 8'h00;
   logic [7:0] m_dir  = 8'h00;
   int         m_edges = 0;
   logic [7:0] pinq[$];

   always @(posedge clk or negedge rst_n) begin
      logic [7:0] old_sync;
      old_sync = (pinq.size() == 2) ? pinq[0] : 8'h00;
      if (clk) begin
         pinq.push_back(pin_in);
         if (pinq.size() > 2) void'(pinq.pop_front());
      end
      if (!rst_n) begin
         m_data = 8'h00;
         m_dir = 8'h00;
         m_edges = 0;
      end else begin
         m_edges++;
         if (m_edges == 2) m_data = old_sync;
         if (bus_sel && bus_wr && bus_addr == 8'h08) m_data = bus_wdata;
         if (bus_sel && bus_wr && bus_addr == 8'h09) m_dir = bus_wdata & 8'hFC;
      end
   end

   // compare every cycle, well after inputs settle and before the next edge
   always @(negedge clk) begin
      #1.5;
      if (pinq.size() == 2) begin
         logic [7:0] e_rd;
         string      tag;
         e_rd = 8'h00;
         tag = "R9";
         if (bus_sel && !bus_wr && bus_addr == 8'h08) begin
            if (emu_mode) begin e_rd = ext_rdata; tag = "R7"; end
            else begin e_rd = (m_dir & m_data) | (~m_dir & pinq[0]); tag = "R4"; end
         end else if (bus_sel && !bus_wr && bus_addr == 8'h09) begin
            e_rd = m_dir; tag = "R5";
         end
         chk({tag, " model rdata"}, bus_rdata, e_rd);
         chk("R6 model pin_oe", pin_oe, m_dir);
         chk("R6 model pin_out", pin_out, m_data & m_dir);
         chk("R7 model ext_wr", {7'd0, ext_wr},
             {7'd0, emu_mode && bus_sel && bus_wr && bus_addr == 8'h08});
         chk("R7 model ext_wdata", ext_wdata, bus_wdata);
         chk("R8 model pull_up", pull_up_en, rst_n ? 8'h00 : 8'h88);
         chk("R8 model pull_dn", pull_dn_en, rst_n ? 8'h00 : 8'h60);
      end
   end

   // ---------------- directed stimulus ----------------
   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] v);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic summary();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      logic [7:0] v;
      // reset state and pulls
      repeat (3) @(negedge clk);
      #1;
      chk("R8 pull_up in reset", pull_up_en, 8'h88);
      chk("R8 pull_dn in reset", pull_dn_en, 8'h60);
      chk("R2 pin_oe in reset", pin_oe, 8'h00);
      chk("R2 pin_out in reset", pin_out, 8'h00);
      rd(8'h09, v);
      chk("R2 dir read in reset", v, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R8 pull_up after reset", pull_up_en, 8'h00);
      // snapshot of A5 on the second edge, then pins change
      repeat (2) @(negedge clk);
      pin_in = 8'h00;
      wr(8'h09, 8'hFC);
      #1 chk("R3 snapshot drives pins", pin_out, 8'hA4);
      rd(8'h08, v);
      chk("R3 snapshot readback", v, 8'hA4);

      // write on the snapshot edge wins
      pin_in = 8'hA5;
      do_reset();
      wr(8'h08, 8'h5A);
      wr(8'h09, 8'hFC);
      #1 chk("R3 write beats snapshot", pin_out, 8'h58);

      // direction register access and fixed low bits
      wr(8'h09, 8'h54);
      rd(8'h09, v);
      chk("R1 dir readback", v, 8'h54);
      wr(8'h09, 8'hFF);
      rd(8'h09, v);
      chk("R5 low dir bits read 0", v, 8'hFC);
      chk("R5 low oe bits 0", pin_oe, 8'hFC);

      // storage independent of direction
      wr(8'h09, 8'h00);
      wr(8'h08, 8'h0F);
      #1 chk("R6 no drive when dir 0", pin_out, 8'h00);
      wr(8'h09, 8'hFC);
      #1 chk("R6 stored value driven", pin_out, 8'h0C);

      // per-bit read selection
      pin_in = 8'h3C;
      wr(8'h08, 8'hA5);
      wr(8'h09, 8'hF0);
      rd(8'h08, v);
      chk("R4 mixed read", v, 8'hAC);

      // emulation mode
      emu_mode = 1'b1;
      ext_rdata = 8'h77;
      rd(8'h08, v);
      chk("R7 emu read", v, 8'h77);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 8'h99;
      #1;
      chk("R7 ext_wr strobe", {7'd0, ext_wr}, 8'h01);
      chk("R7 ext_wdata", ext_wdata, 8'h99);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; emu_mode = 1'b0;
      wr(8'h09, 8'hFF);
      #1 chk("R7 emu write stored", pin_out, 8'h98);

      // unmapped offsets
      rd(8'h10, v);
      chk("R9 unmapped read", v, 8'h00);
      wr(8'h0A, 8'h00);
      wr(8'h07, 8'h00);
      rd(8'h08, v);
      chk("R9 data unchanged", v, 8'h98);
      rd(8'h09, v);
      chk("R9 dir unchanged", v, 8'hFC);

      // randomized phase with a mid-run reset
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (i == 200) rst_n = 1'b0;
         if (i == 204) rst_n = 1'b1;
         bus_sel   = 1'($urandom_range(0, 1));
         bus_wr    = 1'($urandom_range(0, 1));
         bus_addr  = 8'($urandom_range(7, 10));
         bus_wdata = 8'($urandom);
         pin_in    = 8'($urandom);
         emu_mode  = ($urandom_range(0, 3) == 0);
         ext_rdata = 8'($urandom);
      end
      @(negedge clk);
      bus_sel = 1'b0;
      repeat (2) @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         summary();
         $finish;
      end
   end

endmodule